// File: doc/BRIEF.md
# Index Register Address Generator

This block keeps a bank of sixteen pointer registers and turns each operand request into an effective memory address. A request names one pointer and an addressing mode. The mode decides how the address is formed and whether the pointer changes. The address is either the pointer itself, the pointer plus a signed 12-bit constant, or the pointer plus a signed 16-bit data-register value. Two further modes step the pointer: one uses the pointer and then advances it, the other retreats it and then uses it. The step is one or two.

A separate load port writes a base address into any pointer. Each computed address is compared against a legal window supplied on two bound inputs. An address outside that window, or a request with an unused mode code, raises an error flag. An errored request never issues a valid strobe and never alters a pointer. The address, the strobe and the error flag are combinational in the request cycle. Pointer changes take effect at the following clock edge.

Top module: `ixreg_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears every pointer to zero. While `req_vld` is low, `ea_vld` and `ea_err` are both low.
- R2: Mode code 0 (plain) drives `ea_out` with the selected pointer and leaves the pointer unchanged.
- R3: Mode code 1 drives `ea_out` with the pointer plus the 12-bit two's-complement `req_cofs` (-2048 to +2047), sign-extended. The pointer is unchanged.
- R4: Mode code 2 drives `ea_out` with the pointer plus the 16-bit two's-complement `req_dofs`, sign-extended. The pointer is unchanged.
- R5: Mode code 3 drives `ea_out` with the current pointer, and the pointer then grows by 1 when `req_step2` is 0, or by 2 when it is 1.
- R6: Mode code 4 lowers the pointer by 1 when `req_step2` is 0, or by 2 when it is 1. It drives `ea_out` with that lowered value, which is also stored.
- R7: With `ld_en` high, `ld_base` is written into pointer `ld_ptr` at the next clock edge. A request in the same cycle sees the pointer's old value.
- R8: An address below `win_lo` or above `win_hi` raises `ea_err`, with both bounds inclusive and the compare unsigned. In that case `ea_vld` stays low and the pointer keeps its value.
- R9: Mode codes 5, 6 and 7 are reserved. They raise `ea_err`, keep `ea_vld` low and change no pointer.
- R10: If a load and a stepping request target the same pointer in one cycle, the loaded base is what the pointer holds afterwards.
- R11: `ea_out`, `ea_vld` and `ea_err` respond in the same cycle as the request. A pointer update is visible to a request in the next cycle. Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Access request present |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 4 | Pointer index |
| req_step2 | input | 1 | Step size select: 0 steps by 1, 1 steps by 2 |
| req_cofs | input | 12 | Signed constant offset |
| req_dofs | input | 16 | Signed data-register offset value |
| win_lo | input | 32 | Lowest legal address |
| win_hi | input | 32 | Highest legal address |
| ld_en | input | 1 | Base load enable |
| ld_ptr | input | 4 | Pointer index to load |
| ld_base | input | 32 | Base address to load |
| ea_out | output | 32 | Effective address |
| ea_vld | output | 1 | Effective address valid |
| ea_err | output | 1 | Illegal access flag |

## Verification
The address, valid strobe and error flag have no register on their path, so each is due in the same cycle as its request. The bench drives a request just after a falling edge and samples these outputs two nanoseconds later, before the rising edge. A pointer change lands at that rising edge and is due one cycle later. The bench checks it by issuing a plain-mode read in a following cycle with the window opened fully. Nothing is read from the design's internals.

// File: rtl/ixag_pkg.sv
package ixag_pkg;

    localparam int IXAG_NUM_PTR = 16;
    localparam int IXAG_PTR_W   = 32;
    localparam int IXAG_COFS_W  = 12;
    localparam int IXAG_DOFS_W  = 16;

    typedef enum logic [2:0] {
        AM_PLAIN = 3'd0,
        AM_COFS  = 3'd1,
        AM_DOFS  = 3'd2,
        AM_POST  = 3'd3,
        AM_PRE   = 3'd4
    } addr_mode_e;

    typedef struct packed {
        logic                  err;
        logic                  upd;
        logic [IXAG_PTR_W-1:0] ea;
        logic [IXAG_PTR_W-1:0] nxt;
    } ea_res_t;

    function automatic logic in_window(input logic [IXAG_PTR_W-1:0] a,
                                       input logic [IXAG_PTR_W-1:0] lo,
                                       input logic [IXAG_PTR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/ixag_ptr_bank.sv
module ixag_ptr_bank
    import ixag_pkg::*;
#(
    parameter int NUM_PTR = IXAG_NUM_PTR,
    parameter int PTR_W   = IXAG_PTR_W,
    localparam int IDX_W  = $clog2(NUM_PTR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_en,
    input  logic [IDX_W-1:0] mod_idx,
    input  logic [PTR_W-1:0] mod_val,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [PTR_W-1:0] ld_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PTR_W-1:0] rd_val,
    output logic [PTR_W-1:0] ptr_q [NUM_PTR]
);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[g] <= '0;
            end else if (ld_en && (ld_idx == IDX_W'(g))) begin
                ptr_q[g] <= ld_val;
            end else if (mod_en && (mod_idx == IDX_W'(g))) begin
                ptr_q[g] <= mod_val;
            end
        end
    end

    assign rd_val = ptr_q[rd_idx];

    // R10: a load takes priority over a stepping write
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ptr_q[$past(ld_idx)] == $past(ld_val));

endmodule

// File: rtl/ixag_ea_calc.sv
module ixag_ea_calc
    import ixag_pkg::*;
#(
    parameter int PTR_W  = IXAG_PTR_W,
    parameter int COFS_W = IXAG_COFS_W,
    parameter int DOFS_W = IXAG_DOFS_W
) (
    input  logic              req_vld,
    input  logic [2:0]        mode,
    input  logic              step2,
    input  logic [COFS_W-1:0] cofs,
    input  logic [DOFS_W-1:0] dofs,
    input  logic [PTR_W-1:0]  cur,
    input  logic [PTR_W-1:0]  lo,
    input  logic [PTR_W-1:0]  hi,
    output ea_res_t           res
);

    logic [PTR_W-1:0] cofs_x, dofs_x, step;
    logic             legal_mode;

    assign cofs_x = {{(PTR_W-COFS_W){cofs[COFS_W-1]}}, cofs};
    assign dofs_x = {{(PTR_W-DOFS_W){dofs[DOFS_W-1]}}, dofs};
    assign step   = step2 ? PTR_W'(2) : PTR_W'(1);

    always_comb begin
        res        = '0;
        res.nxt    = cur;
        legal_mode = 1'b1;
        unique case (mode)
            AM_PLAIN: res.ea = cur;
            AM_COFS:  res.ea = cur + cofs_x;
            AM_DOFS:  res.ea = cur + dofs_x;
            AM_POST: begin
                res.ea  = cur;
                res.nxt = cur + step;
                res.upd = 1'b1;
            end
            AM_PRE: begin
                res.nxt = cur - step;
                res.ea  = res.nxt;
                res.upd = 1'b1;
            end
            default: begin
                res.ea     = cur;
                legal_mode = 1'b0;
            end
        endcase
        res.err = req_vld && (!legal_mode || !in_window(res.ea, lo, hi));
        res.upd = res.upd && req_vld && !res.err;
    end

endmodule

// File: rtl/ixreg_addr_gen.sv
module ixreg_addr_gen
    import ixag_pkg::*;
#(
    parameter int NUM_PTR = IXAG_NUM_PTR,
    parameter int PTR_W   = IXAG_PTR_W,
    parameter int COFS_W  = IXAG_COFS_W,
    parameter int DOFS_W  = IXAG_DOFS_W,
    localparam int IDX_W  = $clog2(NUM_PTR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [2:0]        req_mode,
    input  logic [IDX_W-1:0]  req_ptr,
    input  logic              req_step2,
    input  logic [COFS_W-1:0] req_cofs,
    input  logic [DOFS_W-1:0] req_dofs,
    input  logic [PTR_W-1:0]  win_lo,
    input  logic [PTR_W-1:0]  win_hi,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_ptr,
    input  logic [PTR_W-1:0]  ld_base,
    output logic [PTR_W-1:0]  ea_out,
    output logic              ea_vld,
    output logic              ea_err
);

    logic [PTR_W-1:0] cur_ptr;
    logic [PTR_W-1:0] ptr_q [NUM_PTR];
    ea_res_t          res;

    ixag_ptr_bank #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .mod_en  (res.upd),
        .mod_idx (req_ptr),
        .mod_val (res.nxt),
        .ld_en   (ld_en),
        .ld_idx  (ld_ptr),
        .ld_val  (ld_base),
        .rd_idx  (req_ptr),
        .rd_val  (cur_ptr),
        .ptr_q   (ptr_q)
    );

    ixag_ea_calc #(.PTR_W(PTR_W), .COFS_W(COFS_W), .DOFS_W(DOFS_W)) i_calc (
        .req_vld (req_vld),
        .mode    (req_mode),
        .step2   (req_step2),
        .cofs    (req_cofs),
        .dofs    (req_dofs),
        .cur     (cur_ptr),
        .lo      (win_lo),
        .hi      (win_hi),
        .res     (res)
    );

    assign ea_out = res.ea;
    assign ea_err = res.err;
    assign ea_vld = req_vld && !res.err;

    // R1: quiet outputs without a request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_vld |-> !ea_vld && !ea_err);

    // R8: a strobed address lies inside the window
    p_vld_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        ea_vld |-> (ea_out >= win_lo) && (ea_out <= win_hi) && !ea_err);

    // R8 / R9: an errored request leaves its pointer alone
    p_err_keeps_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (req_vld && ea_err && !(ld_en && ld_ptr == req_ptr))
        |=> ptr_q[$past(req_ptr)] == $past(ptr_q[req_ptr]));

    // R2: plain mode passes the pointer straight through
    p_plain_ea_r2: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode == AM_PLAIN) |-> ea_out == ptr_q[req_ptr]);

    // R5: post-increment advances the pointer by the selected step
    p_post_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ea_vld && req_mode == AM_POST && !(ld_en && ld_ptr == req_ptr))
        |=> ptr_q[$past(req_ptr)] ==
            $past(ptr_q[req_ptr]) + ($past(req_step2) ? PTR_W'(2) : PTR_W'(1)));

    // R9: reserved codes always error
    p_reserved_err_r9: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_mode > 3'd4) |-> ea_err);

endmodule

// File: tb/test_ixreg_addr_gen.sv
module test_ixreg_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [2:0]  req_mode;
    logic [3:0]  req_ptr;
    logic        req_step2;
    logic [11:0] req_cofs;
    logic [15:0] req_dofs;
    logic [31:0] win_lo, win_hi;
    logic        ld_en;
    logic [3:0]  ld_ptr;
    logic [31:0] ld_base;
    logic [31:0] ea_out;
    logic        ea_vld, ea_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] o_ea;
    logic        o_vld, o_err;

    always #5 clk = ~clk;

    ixreg_addr_gen i_ixreg_addr_gen (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_mode(req_mode),
        .req_ptr(req_ptr), .req_step2(req_step2), .req_cofs(req_cofs),
        .req_dofs(req_dofs), .win_lo(win_lo), .win_hi(win_hi),
        .ld_en(ld_en), .ld_ptr(ld_ptr), .ld_base(ld_base),
        .ea_out(ea_out), .ea_vld(ea_vld), .ea_err(ea_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] m, input logic [3:0] p, input logic s2,
                          input logic [11:0] c, input logic [15:0] d);
        @(negedge clk);
        req_vld = 1'b1; req_mode = m; req_ptr = p; req_step2 = s2;
        req_cofs = c; req_dofs = d;
        #2;
        o_ea = ea_out; o_vld = ea_vld; o_err = ea_err;
        @(posedge clk);
        #1;
        req_vld = 1'b0;
        ld_en   = 1'b0;
    endtask

    task automatic read_ptr(input logic [3:0] p, output logic [31:0] v);
        logic [31:0] lo, hi;
        lo = win_lo; hi = win_hi;
        win_lo = '0; win_hi = '1;
        access(3'd0, p, 1'b0, '0, '0);
        v = o_ea;
        win_lo = lo; win_hi = hi;
    endtask

    task automatic load(input logic [3:0] p, input logic [31:0] b);
        @(negedge clk);
        ld_en = 1'b1; ld_ptr = p; ld_base = b;
        @(posedge clk);
        #1;
        ld_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        #2;
        chk("R1 idle vld", 32'(ea_vld), 0);
        chk("R1 idle err", 32'(ea_err), 0);
        read_ptr(4'd0, v);  chk("R1 p0 after reset", v, 0);
        read_ptr(4'd15, v); chk("R1 p15 after reset", v, 0);
    endtask

    task automatic t_plain_load;
        logic [31:0] v;
        load(4'd3, 32'h0000_1000);
        access(3'd0, 4'd3, 1'b0, '0, '0);
        chk("R2 plain ea", o_ea, 32'h1000);
        chk("R2 plain vld", 32'(o_vld), 1);
        chk("R7 load visible next cycle", o_ea, 32'h1000);
        read_ptr(4'd3, v); chk("R2 ptr unchanged", v, 32'h1000);
    endtask

    task automatic t_const;
        logic [31:0] v;
        access(3'd1, 4'd3, 1'b0, 12'd5, '0);   chk("R3 +5", o_ea, 32'h1005);
        access(3'd1, 4'd3, 1'b0, 12'h800, '0); chk("R3 -2048", o_ea, 32'h0800);
        access(3'd1, 4'd3, 1'b0, 12'h7FF, '0); chk("R3 +2047", o_ea, 32'h17FF);
        read_ptr(4'd3, v); chk("R3 ptr unchanged", v, 32'h1000);
    endtask

    task automatic t_dreg;
        logic [31:0] v;
        access(3'd2, 4'd3, 1'b0, '0, 16'hFFFF); chk("R4 -1", o_ea, 32'h0FFF);
        access(3'd2, 4'd3, 1'b0, '0, 16'h0010); chk("R4 +16", o_ea, 32'h1010);
        access(3'd2, 4'd3, 1'b0, '0, 16'h8000); chk("R4 -32768", o_ea, 32'hFFFF_9000);
        read_ptr(4'd3, v); chk("R4 ptr unchanged", v, 32'h1000);
    endtask

    task automatic t_post;
        logic [31:0] v;
        access(3'd3, 4'd3, 1'b0, '0, '0); chk("R5 inc1 ea", o_ea, 32'h1000);
        access(3'd3, 4'd3, 1'b1, '0, '0); chk("R11 R5 inc2 ea sees prior update", o_ea, 32'h1001);
        read_ptr(4'd3, v); chk("R5 ptr after +1 +2", v, 32'h1003);
    endtask

    task automatic t_pre;
        logic [31:0] v;
        access(3'd4, 4'd3, 1'b1, '0, '0); chk("R6 dec2 ea", o_ea, 32'h1001);
        access(3'd4, 4'd3, 1'b0, '0, '0); chk("R6 dec1 ea", o_ea, 32'h1000);
        read_ptr(4'd3, v); chk("R6 ptr after -2 -1", v, 32'h1000);
    endtask

    task automatic t_window;
        logic [31:0] v;
        win_lo = 32'h0800; win_hi = 32'h2000;
        access(3'd1, 4'd3, 1'b0, 12'h800, '0);
        chk("R8 low bound legal", 32'(o_vld), 1);
        load(4'd5, 32'h0800);
        access(3'd4, 4'd5, 1'b0, '0, '0);
        chk("R8 below lo err", 32'(o_err), 1);
        chk("R8 below lo no vld", 32'(o_vld), 0);
        read_ptr(4'd5, v); chk("R8 ptr kept", v, 32'h0800);
        load(4'd6, 32'h2000);
        access(3'd3, 4'd6, 1'b0, '0, '0);
        chk("R8 high bound legal", 32'(o_vld), 1);
        access(3'd0, 4'd6, 1'b0, '0, '0);
        chk("R8 above hi err", 32'(o_err), 1);
        win_lo = '0; win_hi = '1;
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        access(3'd5, 4'd3, 1'b1, '0, '0);
        chk("R9 code5 err", 32'(o_err), 1);
        chk("R9 code5 no vld", 32'(o_vld), 0);
        access(3'd7, 4'd3, 1'b0, '0, '0);
        chk("R9 code7 err", 32'(o_err), 1);
        read_ptr(4'd3, v); chk("R9 ptr kept", v, 32'h1000);
    endtask

    task automatic t_conflict;
        logic [31:0] v;
        ld_en = 1'b1; ld_ptr = 4'd3; ld_base = 32'h4000;
        access(3'd3, 4'd3, 1'b1, '0, '0);
        chk("R7 same-cycle request sees old", o_ea, 32'h1000);
        read_ptr(4'd3, v); chk("R10 load wins", v, 32'h4000);
        ld_en = 1'b1; ld_ptr = 4'd4; ld_base = 32'h50;
        access(3'd4, 4'd3, 1'b0, '0, '0);
        chk("R11 dec ea", o_ea, 32'h3FFF);
        read_ptr(4'd4, v); chk("R7 other ptr loaded", v, 32'h50);
        read_ptr(4'd3, v); chk("R11 other ptr stepped", v, 32'h3FFF);
        load(4'd7, 32'h0);
        access(3'd4, 4'd7, 1'b1, '0, '0);
        chk("R11 wrap below zero", o_ea, 32'hFFFF_FFFE);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_vld = 1'b0; req_mode = '0; req_ptr = '0; req_step2 = 1'b0;
        req_cofs = '0; req_dofs = '0; win_lo = '0; win_hi = '1;
        ld_en = 1'b0; ld_ptr = '0; ld_base = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_plain_load;
        t_const;
        t_dreg;
        t_post;
        t_pre;
        t_window;
        t_reserved;
        t_conflict;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule